// File: doc/BRIEF.md
# Gated Fractional Reference Clock Bank

This block makes four reference clock enables from one fast source clock. Each channel has its own gate and its own fractional divider. A channel that runs makes a train of one-cycle enable pulses in the source domain. The average pulse rate is the source rate times 18 divided by a 6-bit divisor value, which gives between 18/35 of the source rate and the full source rate. Logic downstream uses each pulse train as a clock enable.

All four channels are controlled through one 32-bit control word. The divisor and gate of channel n sit in byte n of that word. A write port reaches the word through three aliases. A plain write replaces the word. A set alias ORs the written ones into the word. A clear alias removes the written ones from the word. With the set and clear aliases, software can start or stop one channel without a read-modify-write that could disturb the other channels. A combinational read port returns the word.

Each channel uses a phase accumulator. On every source cycle it adds 18. When the sum reaches the effective divisor, the divisor is subtracted and a pulse is issued.

Top module: `refclk_bank`

## Requirements
- R1: During and after reset, and before any write, `rd_data` reads 0x92929292: every byte has its gate set and a divisor of 18. Every `clk_en` bit is 0 and every accumulator starts at zero.
- R2: When `wr_en`=1 and `wr_sel`=0, the control word is replaced by `wr_data` at the next clock edge. Bit 6 of every byte always reads 0.
- R3: When `wr_en`=1 and `wr_sel`=1, the control word becomes its old value OR `wr_data`. Bits written as 0 keep their value.
- R4: When `wr_en`=1 and `wr_sel`=2, every bit written as 1 is cleared. Bits written as 0 keep their value.
- R5: A write with `wr_sel`=3, or any cycle with `wr_en`=0, leaves the control word unchanged.
- R6: Channel n takes its divisor from bits 8n+5..8n. When its gate is clear and the divisor D lies in 18..35, it gives exactly 18 pulses on `clk_en[n]` in any D consecutive cycles once its accumulator is below D.
- R7: A divisor below 18 acts as 18, which gives a pulse on every cycle. A divisor above 35 acts as 35.
- R8: Bit 8n+7 is the gate of channel n, and 1 means stopped. While the gate is set, `clk_en[n]` stays 0 and the accumulator holds its value. The pulse decision made at the edge that writes a gate value still uses the old gate. Clearing the gate lets pulses resume from the next cycle.
- R9: Each `clk_en[n]` is registered and depends only on byte n and the history of channel n. Changing one byte does not change the pulse pattern of the other channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the control word |
| wr_sel | input | 2 | Write alias: 0 plain, 1 set, 2 clear, 3 no effect |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Current control word |
| clk_en | output | 4 | One enable pulse train per channel |

## Verification
Some behaviours are checked by assertions on every cycle:
- the result of each write alias and of idle cycles,
- bit 6 of every byte reading zero,
- a gated channel staying silent,
- a channel with a divisor of 18 or less pulsing on every cycle.

Other behaviours only the bench scenarios can show, by counting pulses over windows and by comparing against a cycle model:
- the exact count of 18 pulses per divisor window,
- the clamp of large divisors to 35,
- the accumulator holding its phase across a gated stretch,
- the channels staying independent.

// File: rtl/refclk_pkg.sv
package refclk_pkg;

   // Write alias selected by wr_sel
   typedef enum logic [1:0] {
      WA_PLAIN = 2'd0,
      WA_SET   = 2'd1,
      WA_CLR   = 2'd2,
      WA_NONE  = 2'd3
   } wr_alias_e;

   localparam int unsigned RATIO_NUM = 18;

endpackage

// File: rtl/refclk_ctrl_reg.sv
module refclk_ctrl_reg
   import refclk_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned FRAC_W   = 6,
   parameter int unsigned RST_FRAC = 18,
   localparam int unsigned REG_W   = NUM_CH * LANE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] ctrl_q
);

   localparam int unsigned PAD_W = LANE_W - 1 - FRAC_W;

   logic [REG_W-1:0] keep_mask;
   logic [REG_W-1:0] rst_word;
   logic [REG_W-1:0] ctrl_nxt;

   // Per-byte layout: gate in the top bit, divisor in the low bits, pad bits read 0
   for (genvar l = 0; l < NUM_CH; l++) begin : g_lane
      assign keep_mask[l*LANE_W +: LANE_W] = {1'b1, {PAD_W{1'b0}}, {FRAC_W{1'b1}}};
      assign rst_word[l*LANE_W +: LANE_W]  = {1'b1, {PAD_W{1'b0}}, FRAC_W'(RST_FRAC)};
   end

   always_comb begin
      unique case (wr_alias_e'(wr_sel))
         WA_PLAIN: ctrl_nxt = wr_data & keep_mask;
         WA_SET:   ctrl_nxt = (ctrl_q | wr_data) & keep_mask;
         WA_CLR:   ctrl_nxt = ctrl_q & ~wr_data;
         default:  ctrl_nxt = ctrl_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= rst_word;
      end else if (wr_en) begin
         ctrl_q <= ctrl_nxt;
      end
   end

endmodule

// File: rtl/refclk_frac_div.sv
module refclk_frac_div #(
   parameter int unsigned FRAC_W   = 6,
   parameter int unsigned ACC_W    = 6,
   parameter int unsigned NUMER    = 18,
   parameter int unsigned FRAC_MIN = 18,
   parameter int unsigned FRAC_MAX = 35
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              gate,
   input  logic [FRAC_W-1:0] frac,
   output logic              pulse
);

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] frac_eff;
   logic [ACC_W-1:0] sum;
   logic             hit;

   // Out-of-range divisors are pulled into the legal window
   always_comb begin
      if (frac < FRAC_W'(FRAC_MIN)) begin
         frac_eff = ACC_W'(FRAC_MIN);
      end else if (frac > FRAC_W'(FRAC_MAX)) begin
         frac_eff = ACC_W'(FRAC_MAX);
      end else begin
         frac_eff = ACC_W'(frac);
      end
   end

   assign sum = acc_q + ACC_W'(NUMER);
   assign hit = (sum >= frac_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         pulse <= 1'b0;
      end else if (gate) begin
         pulse <= 1'b0;
      end else begin
         acc_q <= hit ? (sum - frac_eff) : sum;
         pulse <= hit;
      end
   end

endmodule

// File: rtl/refclk_bank.sv
module refclk_bank
   import refclk_pkg::*;
#(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned FRAC_W   = 6,
   parameter int unsigned FRAC_MIN = 18,
   parameter int unsigned FRAC_MAX = 35,
   localparam int unsigned REG_W   = NUM_CH * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   output logic [NUM_CH-1:0] clk_en
);

   localparam int unsigned ACC_W = $clog2(FRAC_MAX + RATIO_NUM + 1);

   if (LANE_W < FRAC_W + 2) begin : g_bad_lane
      $error("refclk_bank: LANE_W must leave room for gate and one pad bit");
   end
   if (FRAC_MAX >= (1 << FRAC_W) || FRAC_MIN > FRAC_MAX) begin : g_bad_range
      $error("refclk_bank: divisor range does not fit FRAC_W");
   end
   if (FRAC_MIN < RATIO_NUM) begin : g_bad_min
      $error("refclk_bank: FRAC_MIN below numerator would exceed source rate");
   end

   logic [REG_W-1:0] ctrl_q;

   refclk_ctrl_reg #(
      .NUM_CH   (NUM_CH),
      .LANE_W   (LANE_W),
      .FRAC_W   (FRAC_W),
      .RST_FRAC (FRAC_MIN)
   ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .ctrl_q  (ctrl_q)
   );

   assign rd_data = ctrl_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      refclk_frac_div #(
         .FRAC_W   (FRAC_W),
         .ACC_W    (ACC_W),
         .NUMER    (RATIO_NUM),
         .FRAC_MIN (FRAC_MIN),
         .FRAC_MAX (FRAC_MAX)
      ) u_div (
         .clk   (clk),
         .rst_n (rst_n),
         .gate  (ctrl_q[c*LANE_W + LANE_W - 1]),
         .frac  (ctrl_q[c*LANE_W +: FRAC_W]),
         .pulse (clk_en[c])
      );
   end

endmodule

// File: rtl/refclk_bank_chk.sv
module refclk_bank_chk #(
   parameter int unsigned NUM_CH   = 4,
   parameter int unsigned LANE_W   = 8,
   parameter int unsigned FRAC_W   = 6,
   parameter int unsigned FRAC_MIN = 18,
   localparam int unsigned REG_W   = NUM_CH * LANE_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [1:0]        wr_sel,
   input logic [REG_W-1:0]  wr_data,
   input logic [REG_W-1:0]  rd_data,
   input logic [NUM_CH-1:0] clk_en
);

   function automatic logic [REG_W-1:0] pad_bits();
      logic [REG_W-1:0] m;
      m = '0;
      for (int b = 0; b < REG_W; b++) begin
         if ((b % LANE_W) >= FRAC_W && (b % LANE_W) < LANE_W - 1) m[b] = 1'b1;
      end
      return m;
   endfunction

   localparam logic [REG_W-1:0] PAD = pad_bits();

   AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & PAD) == '0);                                               // R2

   AST_PLAIN_WR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd0) |=> rd_data == ($past(wr_data) & ~PAD));   // R2

   AST_SET_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd1) |=>
         rd_data == (($past(rd_data) | $past(wr_data)) & ~PAD));            // R3

   AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel == 2'd2) |=>
         rd_data == ($past(rd_data) & ~$past(wr_data)));                    // R4

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en || wr_sel == 2'd3) |=> $stable(rd_data));                     // R5

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      AST_GATED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         rd_data[c*LANE_W + LANE_W - 1] |=> !clk_en[c]);                    // R8

      AST_MIN_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
         (!rd_data[c*LANE_W + LANE_W - 1] &&
          rd_data[c*LANE_W +: FRAC_W] <= FRAC_W'(FRAC_MIN)) |=> clk_en[c]); // R7
   end

endmodule

bind refclk_bank refclk_bank_chk #(
   .NUM_CH   (NUM_CH),
   .LANE_W   (LANE_W),
   .FRAC_W   (FRAC_W),
   .FRAC_MIN (FRAC_MIN)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .wr_sel  (wr_sel),
   .wr_data (wr_data),
   .rd_data (rd_data),
   .clk_en  (clk_en)
);

// File: tb/refclk_bank_test.sv
module refclk_bank_test;

   localparam int CLK_P = 10;
   localparam logic [31:0] RST_WORD = 32'h9292_9292;
   localparam logic [31:0] KEEP     = 32'hBFBF_BFBF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = '0;
   logic [31:0] rd_data;
   logic [3:0]  clk_en;

   int n_chk = 0;
   int n_err = 0;
   bit mon_on = 1'b0;

   refclk_bank uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .clk_en  (clk_en)
   );

   always #(CLK_P/2) clk = ~clk;

   // Cycle model built from the requirements
   logic [31:0] m_reg;
   int          m_acc [4];
   logic [3:0]  m_pulse;

   function automatic int eff_div(logic [5:0] f);
      if (f < 6'd18) return 18;
      if (f > 6'd35) return 35;
      return int'(f);
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_reg = RST_WORD;
         m_pulse = '0;
         for (int c = 0; c < 4; c++) m_acc[c] = 0;
      end else begin
         for (int c = 0; c < 4; c++) begin
            if (m_reg[8*c+7]) begin
               m_pulse[c] = 1'b0;
            end else begin
               int s, d;
               s = m_acc[c] + 18;
               d = eff_div(m_reg[8*c +: 6]);
               if (s >= d) begin m_acc[c] = s - d; m_pulse[c] = 1'b1; end
               else begin m_acc[c] = s; m_pulse[c] = 1'b0; end
            end
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: m_reg = wr_data & KEEP;
               2'd1: m_reg = (m_reg | wr_data) & KEEP;
               2'd2: m_reg = m_reg & ~wr_data;
               default: ;
            endcase
         end
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", req, act, exp, $time);
      end
   endtask

   // Per-cycle comparison against the model, sampled a quarter period after the edge
   always begin
      @(posedge clk);
      #(CLK_P/4);
      if (mon_on) begin
         check("R2/R3/R4/R5 control word", rd_data, m_reg);
         check("R6/R8/R9 pulse trains", {28'd0, clk_en}, {28'd0, m_pulse});
      end
   end

   task automatic wr(input logic [1:0] sel, input logic [31:0] data);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = data;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic count_pulses(input int ch, input int cycles, output int cnt);
      cnt = 0;
      repeat (cycles) begin
         @(posedge clk);
         #(CLK_P/4);
         cnt += int'(clk_en[ch]);
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      int cnt;
      void'($urandom(32'd5417));

      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset word", rd_data, RST_WORD);
      check("R1 enables idle", {28'd0, clk_en}, 32'd0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      check("R1 word after reset", rd_data, RST_WORD);
      check("R1 enables gated", {28'd0, clk_en}, 32'd0);
      mon_on = 1'b1;

      // R2: plain write, bit 6 forced to zero
      wr(2'd0, 32'hFFFF_FFFF);
      check("R2 pad bit reads 0", rd_data, 32'hBFBF_BFBF);
      wr(2'd0, 32'h5A12_1B24);
      check("R2 plain write", rd_data, 32'h1A12_1B24);

      // R5: reserved alias and idle cycles
      wr(2'd3, 32'h0000_0000);
      check("R5 alias 3 ignored", rd_data, 32'h1A12_1B24);

      // R3 / R4: set and clear aliases touch only written ones
      wr(2'd1, 32'h8000_0000);
      check("R3 set alias", rd_data, 32'h9A12_1B24);
      wr(2'd2, 32'h8000_0001);
      check("R4 clear alias", rd_data, 32'h1A12_1B24 & ~32'h1);

      // R6: exact pulse count per divisor window, ch1 divisor 27
      wr(2'd0, 32'h8080_1B80);
      repeat (40) @(negedge clk);
      count_pulses(1, 27 * 4, cnt);
      check("R6 divisor 27 window", cnt, 72);

      // R7: small divisor acts as 18, large acts as 35
      wr(2'd0, 32'h8080_8005);
      count_pulses(0, 20, cnt);
      check("R7 divisor 5 every cycle", cnt, 20);
      wr(2'd0, 32'h8080_803C);
      repeat (40) @(negedge clk);
      count_pulses(0, 70, cnt);
      check("R7 divisor 60 acts as 35", cnt, 36);

      // R8: gate stops, resume on next cycle; R9: other channel unaffected
      wr(2'd0, 32'h8012_8012);
      wr(2'd1, 32'h0000_0080);
      count_pulses(0, 10, cnt);
      check("R8 gated channel silent", cnt, 0);
      wr(2'd2, 32'h0000_0080);
      count_pulses(0, 10, cnt);
      check("R8 resume after ungate", cnt, 10);
      count_pulses(2, 10, cnt);
      check("R9 neighbour keeps running", cnt, 10);

      // Random traffic compared with the model each cycle
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         wr_en   = ($urandom % 4) == 0;
         wr_sel  = 2'($urandom % 4);
         wr_data = $urandom;
      end
      @(negedge clk);
      wr_en = 1'b0;
      repeat (4) @(negedge clk);

      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule